// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is a synchronous serial master that runs half-duplex transactions with exactly one slave device. Software-side logic writes 8-bit control words into a small transmit queue. Each queued word becomes one frame. In a frame the select line drops and the control byte is shifted out MSB first. The master then gives the slave one full serial clock period to decode the byte. After that it clocks in a response word and releases the select line. The response is between 4 and 16 bits long, set by configuration. It is stored right-justified and zero-filled in a 16-bit receive queue.

The serial clock runs only during a frame. Its half period is a programmable number of system clocks, so the whole frame timing follows from the divider and the response length. Frames run one at a time. When more control words are waiting, the next frame starts after a single idle system cycle. A full receive queue holds back the next frame until a response has been read. There is no slave addressing, and the select line is a single wire.

Top module: `mw_master`

## Requirements
- R1: Out of reset and between frames, `sclk` is low, `ssel_n` is high, `busy` is low, the response queue is empty and the command queue is not full.
- R2: When a control word is written while the block is idle and the response queue has room, `ssel_n` falls on the second rising system clock edge after the write cycle. That is, it is still high right after the write edge and low right after the next edge.
- R3: The 8 control bits leave on `sdo` MSB first. `sdo` changes only while `sclk` is low, so a slave that samples on each of the first 8 rising `sclk` edges captures the written byte.
- R4: Every frame has exactly 9+N rising `sclk` edges, where N is the effective response length. Edges 1 to 8 carry control bits. Edge 9 ends the one-period decode gap. Edges 10 to 9+N sample `sdi`, and the slave changes `sdi` on falling edges.
- R5: The effective response length N is `cfg_rsp_len` clamped to the range 4..16. A value below 4 gives 4 and a value above 16 gives 16. It is latched at frame start.
- R6: The response word read from `rsp_rdata` holds the N sampled bits right-justified, with the first sampled bit as bit N-1, and zeros above bit N-1.
- R7: `ssel_n` rises one full `sclk` period after the last sampling edge, with `sclk` low at that moment. The frame lasts (19+2N)·D system clocks from the fall of `ssel_n` to its rise.
- R8: Each `sclk` half period is D system clocks, where D is `cfg_div`, with 0 treated as 1. D is latched at frame start.
- R9: `busy` is high exactly while `ssel_n` is low.
- R10: If control words remain queued when a frame ends, the next frame's `ssel_n` falls exactly one system clock after the previous rise. If the queue is empty, the block stays idle.
- R11: No frame starts while the response queue is full. The frame starts once a response has been read.
- R12: Both queues hold 4 entries. `cmd_full` is high with 4 waiting words, and a write while full is dropped. A read of the empty response queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rsp_len | input | 5 | Response length in bits (clamped to 4..16) |
| cfg_div | input | 8 | Serial clock half period in system clocks (0 acts as 1) |
| cmd_wdata | input | 8 | Control word to queue |
| cmd_wr | input | 1 | Write strobe for the command queue |
| cmd_full | output | 1 | Command queue full |
| rsp_rdata | output | 16 | Oldest response word, right-justified |
| rsp_rd | input | 1 | Pop strobe for the response queue |
| rsp_empty | output | 1 | Response queue empty |
| sclk | output | 1 | Serial clock |
| ssel_n | output | 1 | Frame select, active low |
| sdo | output | 1 | Serial data to slave |
| sdi | input | 1 | Serial data from slave |
| busy | output | 1 | Frame in progress |

## Verification
Two pairs of events can land in the same system cycle. The first is a command queue write and the frame engine popping that queue to start a frame. The second is the end of a frame, which pushes a response, and the start of the next frame, which is decided from the response queue level in the same cycle. The bench writes four control words on consecutive cycles, so the pop that starts the first frame coincides with a later write. It then lets the frames run back to back until the response queue fills. The outcome is judged from the byte captured by a behavioural slave for each frame, the one-cycle spacing between frames, the stall once the queue is full, and the order and content of the words read back.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int CTRL_W = 8;
  localparam int RSP_W  = 16;
  localparam int LEN_W  = 5;
  localparam int HALF_W = 6;

  typedef enum logic {FR_IDLE, FR_ACTIVE} fr_state_e;

  // effective response length, 4..16
  function automatic logic [LEN_W-1:0] fr_clamp_len(input logic [LEN_W-1:0] l);
    if (l < LEN_W'(4))       return LEN_W'(4);
    else if (l > LEN_W'(16)) return LEN_W'(16);
    else                     return l;
  endfunction

  // half-period divider, zero behaves as one
  function automatic logic [7:0] fr_clamp_div(input logic [7:0] d);
    return (d == 8'd0) ? 8'd1 : d;
  endfunction

  // half-tick index on which the select line is released
  function automatic logic [HALF_W-1:0] fr_end_half(input logic [LEN_W-1:0] n);
    return HALF_W'(2*CTRL_W + 3) + {n, 1'b0};
  endfunction

  // half ticks on which the serial clock toggles
  function automatic logic fr_is_toggle(input logic [HALF_W-1:0] h, input logic [LEN_W-1:0] n);
    return h <= HALF_W'(2*CTRL_W + 2) + {n, 1'b0};
  endfunction

  // falling edges inside the control phase present the next bit
  function automatic logic fr_is_shift(input logic [HALF_W-1:0] h);
    return !h[0] && (h < HALF_W'(2*CTRL_W));
  endfunction

  // rising edges on which response bits are sampled
  function automatic logic fr_is_sample(input logic [HALF_W-1:0] h, input logic [LEN_W-1:0] n);
    return h[0] && (h >= HALF_W'(2*CTRL_W + 3)) && (h <= HALF_W'(2*CTRL_W + 1) + {n, 1'b0});
  endfunction
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic wr_ok, rd_ok;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end
  end

  AST_FIFO_COUNT_LE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R12
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R12
endmodule

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);
  logic [DIV_W-1:0] cnt;

  assign half_tick = run && (cnt == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_DIV_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div != '0) |-> cnt < div); // R8
endmodule

// File: rtl/mw_frame_fsm.sv
module mw_frame_fsm
  import mw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                tx_valid,
  input  logic [CTRL_W-1:0]   tx_data,
  output logic                tx_pop,
  input  logic                rx_full,
  output logic                rsp_push,
  output logic [RSP_W-1:0]    rsp_word,
  input  logic                sdi,
  output logic                sclk,
  output logic                ssel_n,
  output logic                sdo,
  output logic                busy
);
  fr_state_e         state;
  logic [HALF_W-1:0] hcnt, nxt_h;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q;
  logic [CTRL_W-1:0] ctrl_sh;
  logic [RSP_W-1:0]  rsp_sh;
  logic sclk_q, ssel_q, sdo_q;
  logic frame_start, half_tick, frame_end;

  // named events for the checks
  assign frame_start = (state == FR_IDLE) && tx_valid && !rx_full;
  assign nxt_h       = hcnt + 1'b1;
  assign frame_end   = (state == FR_ACTIVE) && half_tick && (nxt_h == fr_end_half(len_q));

  mw_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == FR_ACTIVE),
    .div       (div_q),
    .half_tick (half_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      hcnt    <= '0;
      len_q   <= LEN_W'(4);
      div_q   <= DIV_W'(1);
      ctrl_sh <= '0;
      rsp_sh  <= '0;
      sclk_q  <= 1'b0;
      ssel_q  <= 1'b1;
      sdo_q   <= 1'b0;
    end else if (frame_start) begin
      state   <= FR_ACTIVE;
      hcnt    <= '0;
      len_q   <= fr_clamp_len(cfg_len);
      div_q   <= DIV_W'(fr_clamp_div(8'(cfg_div)));
      ctrl_sh <= tx_data;
      sdo_q   <= tx_data[CTRL_W-1];
      rsp_sh  <= '0;
      ssel_q  <= 1'b0;
    end else if (state == FR_ACTIVE && half_tick) begin
      hcnt <= nxt_h;
      if (fr_is_toggle(nxt_h, len_q)) sclk_q <= ~sclk_q;
      if (fr_is_shift(nxt_h)) begin
        ctrl_sh <= {ctrl_sh[CTRL_W-2:0], 1'b0};
        sdo_q   <= ctrl_sh[CTRL_W-2];
      end else if (nxt_h == HALF_W'(2*CTRL_W)) begin
        sdo_q <= 1'b0;
      end
      if (fr_is_sample(nxt_h, len_q)) rsp_sh <= {rsp_sh[RSP_W-2:0], sdi};
      if (frame_end) begin
        ssel_q <= 1'b1;
        state  <= FR_IDLE;
      end
    end
  end

  assign tx_pop   = frame_start;
  assign rsp_push = frame_end;
  assign rsp_word = rsp_sh;
  assign sclk     = sclk_q;
  assign ssel_n   = ssel_q;
  assign sdo      = sdo_q;
  assign busy     = (state == FR_ACTIVE);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_q && ssel_q)); // R1
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdo_q)); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q >= LEN_W'(4) && len_q <= LEN_W'(16))); // R5
  AST_SELECT_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssel_q) |-> !sclk_q); // R7
  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(sclk_q)); // R8
  AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    busy != ssel_q); // R9
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RSP_DEPTH = 4,
  parameter int DIV_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   cfg_rsp_len,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [CTRL_W-1:0]  cmd_wdata,
  input  logic               cmd_wr,
  output logic               cmd_full,
  output logic [RSP_W-1:0]   rsp_rdata,
  input  logic               rsp_rd,
  output logic               rsp_empty,
  output logic               sclk,
  output logic               ssel_n,
  output logic               sdo,
  input  logic               sdi,
  output logic               busy
);
  logic [CTRL_W-1:0] tx_data;
  logic tx_empty, tx_pop;
  logic rx_full, rsp_push;
  logic [RSP_W-1:0] rsp_word;

  mw_fifo #(.W(CTRL_W), .DEPTH(CMD_DEPTH)) i_cmd_q (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_wr), .din(cmd_wdata),
    .pop(tx_pop), .dout(tx_data),
    .full(cmd_full), .empty(tx_empty)
  );

  mw_fifo #(.W(RSP_W), .DEPTH(RSP_DEPTH)) i_rsp_q (
    .clk(clk), .rst_n(rst_n),
    .push(rsp_push), .din(rsp_word),
    .pop(rsp_rd), .dout(rsp_rdata),
    .full(rx_full), .empty(rsp_empty)
  );

  mw_frame_fsm #(.DIV_W(DIV_W)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .cfg_len(cfg_rsp_len), .cfg_div(cfg_div),
    .tx_valid(!tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rsp_push(rsp_push), .rsp_word(rsp_word),
    .sdi(sdi), .sclk(sclk), .ssel_n(ssel_n), .sdo(sdo), .busy(busy)
  );

  AST_RSP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_push |-> !rx_full); // R11
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R10
endmodule

// File: tb/test_mw_master.sv
module test_mw_master;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0]  cfg_rsp_len = 5'd8;
  logic [7:0]  cfg_div = 8'd1;
  logic [7:0]  cmd_wdata = 8'd0;
  logic        cmd_wr = 0, rsp_rd = 0, sdi = 0;
  logic        cmd_full, rsp_empty, sclk, ssel_n, sdo, busy;
  logic [15:0] rsp_rdata;

  int total = 0, bad = 0, frames_done = 0, cur_len = 8;
  bit finished = 0;
  logic [7:0] cap_log [0:127];
  int         rise_log [0:127];
  longint     dur_log [0:127];
  longint     gap_log [0:127];

  always #(CLK_P/2) clk = ~clk;

  mw_master i_mw_master (
    .clk(clk), .rst_n(rst_n), .cfg_rsp_len(cfg_rsp_len), .cfg_div(cfg_div),
    .cmd_wdata(cmd_wdata), .cmd_wr(cmd_wr), .cmd_full(cmd_full),
    .rsp_rdata(rsp_rdata), .rsp_rd(rsp_rd), .rsp_empty(rsp_empty),
    .sclk(sclk), .ssel_n(ssel_n), .sdo(sdo), .sdi(sdi), .busy(busy)
  );

  function automatic logic [15:0] exp_resp(input logic [7:0] c, input int n);
    logic [16:0] m;
    m = (17'h1 << n) - 17'h1;
    return {c, c ^ 8'hA5} & m[15:0];
  endfunction

  task automatic chk(input longint act, input longint exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural slave: samples on rising sclk, answers on falling sclk
  initial begin : slave
    time t_prev = 0, t_fall;
    logic [7:0] cap;
    logic [15:0] v;
    int r, f, n;
    forever begin
      @(negedge ssel_n);
      t_fall = $time; cap = 0; r = 0; f = 0; n = cur_len; v = 0;
      forever begin
        @(sclk or ssel_n);
        if (ssel_n) break;
        if (sclk) begin
          r++;
          if (r <= 8) cap = {cap[6:0], sdo};
          if (r == 8) v = exp_resp(cap, n);
        end else begin
          f++;
          if (f >= 9 && (f - 9) < n) begin
            #1 sdi = v[n - 1 - (f - 9)];
          end
        end
      end
      cap_log[frames_done % 128]  = cap;
      rise_log[frames_done % 128] = r;
      dur_log[frames_done % 128]  = longint'($time - t_fall);
      gap_log[frames_done % 128]  = longint'(t_fall - t_prev);
      t_prev = $time;
      frames_done++;
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  task automatic write_cmd(input logic [7:0] c);
    @(negedge clk); cmd_wdata = c; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic run_frame(input logic [7:0] c, input int len_cfg, input int div_cfg,
                           input int n, input int d, input string tg);
    int idx;
    idx = frames_done;
    cfg_rsp_len = 5'(len_cfg); cfg_div = 8'(div_cfg); cur_len = n;
    write_cmd(c);
    wait (frames_done == idx + 1);
    @(negedge clk); @(negedge clk);
    chk(cap_log[idx % 128], c, "R3 control byte");
    chk(rise_log[idx % 128], 9 + n, {tg, " rising edge count"});
    chk(dur_log[idx % 128], longint'((19 + 2*n) * d * CLK_P), "R7/R8 frame length");
    chk(rsp_empty, 0, "R6 word present");
    chk(rsp_rdata, exp_resp(c, n), "R6 response word");
    rsp_rd = 1; @(negedge clk); rsp_rd = 0;
    chk({sclk, ssel_n, busy}, 3'b010, "R1 idle after frame");
  endtask

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sclk, 0, "R1 sclk"); chk(ssel_n, 1, "R1 ssel_n"); chk(busy, 0, "R1 busy");
    chk(rsp_empty, 1, "R1 rsp_empty"); chk(cmd_full, 0, "R1 cmd_full");

    // R2: start latency
    cfg_rsp_len = 5'd8; cfg_div = 8'd2; cur_len = 8;
    base = frames_done;
    cmd_wdata = 8'h3C; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    chk(ssel_n, 1, "R2 before start");
    @(negedge clk);
    chk(ssel_n, 0, "R2 select fell"); chk(busy, 1, "R9 busy in frame");
    wait (frames_done == base + 1);
    @(negedge clk); @(negedge clk);
    chk(cap_log[base % 128], 8'h3C, "R3 first byte");
    chk(rsp_rdata, exp_resp(8'h3C, 8), "R6 first word");
    rsp_rd = 1; @(negedge clk); rsp_rd = 0;

    // sweep of divider and response length
    for (int d = 1; d <= 3; d++)
      for (int n = 4; n <= 16; n++)
        run_frame(8'(8'h5A ^ (n * 37 + d * 11)), n, d, n, d, "R4");

    // clamping
    run_frame(8'hC3, 2, 1, 4, 1, "R5 low clamp");
    run_frame(8'h81, 20, 1, 16, 1, "R5 high clamp");
    run_frame(8'h7E, 31, 2, 16, 2, "R5 top clamp");
    run_frame(8'h19, 6, 0, 6, 1, "R8 zero divider");

    // back to back, queue coincidences, full response queue
    cfg_rsp_len = 5'd4; cfg_div = 8'd1; cur_len = 4;
    base = frames_done;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cmd_wdata = 8'(8'h10 + k); cmd_wr = 1;
    end
    @(negedge clk); cmd_wr = 0;
    wait (frames_done == base + 4);
    for (int k = 1; k < 4; k++) chk(gap_log[(base + k) % 128], CLK_P, "R10 one-cycle gap");
    for (int k = 0; k < 4; k++) chk(cap_log[(base + k) % 128], 8'h10 + k, "R3 queued byte");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); cmd_wdata = 8'(8'h20 + k); cmd_wr = 1;
    end
    @(negedge clk); cmd_wr = 0;
    chk(cmd_full, 1, "R12 command queue full");
    repeat (100) @(negedge clk);
    chk(busy, 0, "R11 stalled on full queue");
    chk(frames_done, base + 4, "R11 no frame while full");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rsp_rdata, exp_resp(8'(8'h10 + k), 4), "R6 queued word");
      rsp_rd = 1;
    end
    @(negedge clk); rsp_rd = 0;
    wait (frames_done == base + 8);
    repeat (60) @(negedge clk);
    chk(frames_done, base + 8, "R12 dropped fifth write");
    chk(busy, 0, "R10 idle when queue empty");
    for (int k = 0; k < 4; k++) chk(cap_log[(base + 4 + k) % 128], 8'h20 + k, "R12 kept writes");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rsp_rdata, exp_resp(8'(8'h20 + k), 4), "R6 second batch");
      rsp_rd = 1;
    end
    @(negedge clk); rsp_rd = 0;
    chk(rsp_empty, 1, "R12 drained");
    rsp_rd = 1; @(negedge clk); rsp_rd = 0; @(negedge clk);
    chk(rsp_empty, 1, "R12 pop on empty ignored");
    run_frame(8'hE7, 9, 1, 9, 1, "R12 after empty pop");

    finished = 1;
    report();
  end
endmodule